// File: doc/BRIEF.md
# Stall-Triggered Hardware Thread Arbiter

This block decides which of eight hardware thread contexts drives the execution pipeline of a small packet-processing engine. It keeps a ready/blocked bit per context. A context becomes blocked when it stalls. A per-context wake pulse makes it ready again, for example when a memory read completes. The running context keeps the pipeline until it raises a stall request. There is no time slice.

On an accepted stall the arbiter searches the other contexts in round-robin order. The search starts just after the stalling context and the stalling context comes last. The first ready one takes the pipeline on the next clock edge. The search itself costs no cycle. A flush indication is then raised for a fixed number of bubble cycles, three by default, to model the pipeline drain. If nothing is ready, the engine goes idle and waits for any wake pulse.

Top module: `thr_switch_arb`

## Requirements
- R1: A synchronous active-low reset makes context 0 ready and granted. All other contexts become blocked, `idle_o` and `flush_o` are 0. A stall right after reset with no wake therefore idles the engine.
- R2: A stall accepted from the running context moves `grant_o` on the next edge to the first context that is ready or waking. The search order is grant+1, grant+2, …, wrapping from 7 to 0.
- R3: Every grant change to a different context raises `flush_o` in the same cycle as the new grant. It stays high for exactly FLUSH_CYCLES (3) consecutive cycles.
- R4: A stall request while `flush_o` is high is ignored: the grant does not move and the flush is not restarted.
- R5: A stalling context is blocked. It is not chosen again until its wake bit is asserted in a later cycle. A wake in the same cycle as its own stall does not unblock it.
- R6: When no other context is ready at an accepted stall, `idle_o` rises on the next edge, `grant_o` keeps the last context and `flush_o` stays 0.
- R7: While idle, a wake on any context clears `idle_o` on the next edge and grants that context. If several wake together, the round-robin order starting after the last granted context picks the winner.
- R8: If the context granted when leaving idle is the one that was granted before idling, no flush cycles are inserted.
- R9: A wake on a context that is already ready has no effect. A stall request while idle is ignored.
- R10: Outside an accepted stall or an exit from idle, `grant_o` never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_req_i | input | 1 | Stall request from the running context |
| wake_i | input | 8 | Per-context wake pulses (bit n = context n) |
| grant_o | output | 3 | Index of the context owning the pipeline |
| idle_o | output | 1 | High while no context is ready and the engine waits |
| flush_o | output | 1 | High during the flush bubble cycles after a switch |

## Verification
The bench targets the points where a search or timing slip is easy to miss:
- **Wrap from 7 to 0.** A search that does not wrap would idle the engine or pick a higher index.
- **Stalls during the flush.** A design that honoured them would hop a second time before the drain ends.
- **A wake arriving with the stalling context's own stall.** A wrong priority would re-grant that same context.
- **Flush length.** An off-by-one counter shows as two or four bubble cycles instead of three.
- **Exit from idle.** The cases are re-granting the same context, which must show no bubbles, and choosing between several simultaneous wakes, where scanning from index 0 instead of after the last grant picks the wrong one.
- **Reset in mid-flush.** This shows whether stale ready bits survive reset.

// File: rtl/thr_arb_pkg.sv
// Package: shared constants and helpers for the thread arbiter.
// Assumes: context counts are small (a few tens at most).
package thr_arb_pkg;

    localparam int unsigned CTX_COUNT_DEF   = 8;
    localparam int unsigned FLUSH_DEPTH_DEF = 3;

    // Width of an index able to address n items (at least 1 bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 0) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/thr_rr_pick.sv
// Module: combinational round-robin search over a request vector.
// Scans base+1, base+2, ... base+N (wrapping), so base itself is last.
// Assumes: base_i < N; no power-of-two restriction on N.
module thr_rr_pick
    import thr_arb_pkg::*;
#(
    parameter int unsigned N  = CTX_COUNT_DEF,
    localparam int unsigned IW = idx_width(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] base_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    int unsigned cand;

    // Find the first requesting entry after base, wrapping at N.
    always_comb begin
        found_o = 1'b0;
        idx_o   = base_i;
        cand    = 0;
        for (int unsigned off = 1; off <= N; off++) begin
            cand = int'(base_i) + off;
            if (cand >= N) begin
                cand = cand - N;
            end
            if (!found_o && req_i[cand]) begin
                found_o = 1'b1;
                idx_o   = cand[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/thr_flush_timer.sv
// Module: counts the pipeline flush bubbles that follow a context switch.
// load_i starts a fresh run of DEPTH busy cycles on the next edge.
// Assumes: load_i is only raised while the timer is not busy.
module thr_flush_timer
    import thr_arb_pkg::*;
#(
    parameter int unsigned DEPTH = FLUSH_DEPTH_DEF,
    localparam int unsigned CW   = cnt_width(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    generate
        if (DEPTH == 0) begin : g_none
            assign busy_o = 1'b0;
        end else begin : g_cnt
            logic [CW-1:0] cnt_q;

            // Load the bubble count on a switch, then count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (load_i) begin
                    cnt_q <= CW'(DEPTH);
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign busy_o = (cnt_q != '0);

            // R3: the count never exceeds the configured depth.
            p_flush_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= CW'(DEPTH));

            // R4: no reload may arrive while bubbles are still running.
            p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
                busy_o |-> !load_i);
        end
    endgenerate

endmodule

// File: rtl/thr_ready_track.sv
// Module: one ready/blocked bit per context.
// A wake sets the bit, a clear (the stalling context) resets it; clear wins.
// Assumes: clr_i is one-hot or zero.
module thr_ready_track
    import thr_arb_pkg::*;
#(
    parameter int unsigned N = CTX_COUNT_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wake_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] ready_o
);

    // Track readiness: context 0 alone is ready out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_o <= N'(1);
        end else begin
            ready_o <= (ready_o | wake_i) & ~clr_i;
        end
    end

    // R5: a blocked context stays blocked until it sees a wake.
    for (genvar g = 0; g < N; g++) begin : g_chk
        p_block_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!ready_o[g] && !wake_i[g]) |=> !ready_o[g]);
    end

endmodule

// File: rtl/thr_switch_arb.sv
// Module: stall-triggered hardware thread arbiter (top).
// Grants one of NUM_CTX contexts the pipeline, switches only on a stall
// from the running context, idles when nothing is ready and flags a fixed
// flush after every switch to a different context.
// Assumes: stall_req_i comes from the context shown on grant_o.
module thr_switch_arb
    import thr_arb_pkg::*;
#(
    parameter int unsigned NUM_CTX   = CTX_COUNT_DEF,
    parameter int unsigned FLUSH_LEN = FLUSH_DEPTH_DEF,
    localparam int unsigned IW       = idx_width(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_req_i,
    input  logic [NUM_CTX-1:0] wake_i,
    output logic [IW-1:0]      grant_o,
    output logic               idle_o,
    output logic               flush_o
);

    logic [NUM_CTX-1:0] ready_q;
    logic [NUM_CTX-1:0] cur_mask;
    logic [NUM_CTX-1:0] cand_vec;
    logic [NUM_CTX-1:0] clr_vec;
    logic               stall_acc;
    logic               pick_found;
    logic [IW-1:0]      pick_idx;
    logic               flush_load;
    logic [IW-1:0]      grant_d;
    logic               idle_d;

    // One-hot mask of the context currently granted.
    assign cur_mask = NUM_CTX'(1) << grant_o;

    // A stall counts only while running and not draining the pipeline.
    assign stall_acc = stall_req_i && !idle_o && !flush_o;

    // Candidates: ready or waking now; the runner is excluded unless idle.
    assign cand_vec = (ready_q | wake_i) & (idle_o ? '1 : ~cur_mask);

    // Block the stalling context.
    assign clr_vec = stall_acc ? cur_mask : '0;

    thr_ready_track #(.N(NUM_CTX)) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake_i  (wake_i),
        .clr_i   (clr_vec),
        .ready_o (ready_q)
    );

    thr_rr_pick #(.N(NUM_CTX)) u_pick (
        .req_i   (cand_vec),
        .base_i  (grant_o),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // Decide next grant, idle state and whether a flush starts.
    always_comb begin
        grant_d    = grant_o;
        idle_d     = idle_o;
        flush_load = 1'b0;
        if (stall_acc) begin
            if (pick_found) begin
                grant_d    = pick_idx;
                flush_load = 1'b1;
            end else begin
                idle_d = 1'b1;
            end
        end else if (idle_o && pick_found) begin
            idle_d     = 1'b0;
            grant_d    = pick_idx;
            flush_load = (pick_idx != grant_o);
        end
    end

    // Register the grant and idle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= '0;
            idle_o  <= 1'b0;
        end else begin
            grant_o <= grant_d;
            idle_o  <= idle_d;
        end
    end

    thr_flush_timer #(.DEPTH(FLUSH_LEN)) u_flush (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (flush_load),
        .busy_o (flush_o)
    );

    // R10: with no accepted stall and no idle exit the grant holds.
    p_grant_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && !(stall_req_i && !flush_o)) |=> $stable(grant_o));

    // R2: an accepted stall moves the grant or idles the engine.
    p_stall_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && !flush_o && stall_req_i) |=>
            (idle_o || (grant_o != $past(grant_o))));

    // R3: a switch taken while running always shows flush bubbles.
    p_switch_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && !flush_o && stall_req_i) |=> (idle_o || flush_o));

    // R6: the idle engine never reports a flush.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !flush_o);

    // R5: the granted context is ready whenever the engine runs.
    p_active_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |-> ready_q[grant_o]);

    // R7: idle persists until some wake arrives.
    p_idle_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && (wake_i == '0)) |=> idle_o);

    // R8: re-granting the same context from idle costs no bubbles.
    p_regrant_noflush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && (wake_i == cur_mask)) |=>
            (!idle_o && !flush_o && $stable(grant_o)));

endmodule

// File: tb/thr_switch_arb_test.sv
// Bench for thr_switch_arb: a vector table walked cycle by cycle, then
// directed checks for reset (including reset during a flush).
module thr_switch_arb_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall_req_i = 1'b0;
    logic [7:0] wake_i = 8'h00;
    logic [2:0] grant_o;
    logic       idle_o;
    logic       flush_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    thr_switch_arb uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_req_i (stall_req_i),
        .wake_i      (wake_i),
        .grant_o     (grant_o),
        .idle_o      (idle_o),
        .flush_o     (flush_o)
    );

    always #5 clk = ~clk;   // 100 MHz

    // Vector: {stall, wake[7:0], exp_grant[2:0], exp_idle, exp_flush}
    localparam int NV = 33;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 8'h02, 3'd0, 1'b0, 1'b0},  //  1 R9 wake ctx1, ctx0 runs on
        {1'b1, 8'h00, 3'd1, 1'b0, 1'b1},  //  2 R2 R3 switch to 1
        {1'b1, 8'h00, 3'd1, 1'b0, 1'b1},  //  3 R4 stall in flush ignored
        {1'b0, 8'h00, 3'd1, 1'b0, 1'b1},  //  4 R3 bubble 3
        {1'b0, 8'h00, 3'd1, 1'b0, 1'b0},  //  5 R3 flush over
        {1'b0, 8'h80, 3'd1, 1'b0, 1'b0},  //  6 R10 wake 7, no switch
        {1'b1, 8'h00, 3'd7, 1'b0, 1'b1},  //  7 R2 skip 2..6, pick 7
        {1'b0, 8'h00, 3'd7, 1'b0, 1'b1},  //  8
        {1'b0, 8'h00, 3'd7, 1'b0, 1'b1},  //  9
        {1'b0, 8'h00, 3'd7, 1'b0, 1'b0},  // 10
        {1'b0, 8'h06, 3'd7, 1'b0, 1'b0},  // 11 wake 1 and 2
        {1'b1, 8'h00, 3'd1, 1'b0, 1'b1},  // 12 R2 wrap 7->0->1
        {1'b0, 8'h00, 3'd1, 1'b0, 1'b1},  // 13
        {1'b0, 8'h00, 3'd1, 1'b0, 1'b1},  // 14
        {1'b0, 8'h00, 3'd1, 1'b0, 1'b0},  // 15
        {1'b1, 8'h00, 3'd2, 1'b0, 1'b1},  // 16 R5 ctx1 blocked, pick 2
        {1'b0, 8'h00, 3'd2, 1'b0, 1'b1},  // 17
        {1'b0, 8'h00, 3'd2, 1'b0, 1'b1},  // 18
        {1'b0, 8'h00, 3'd2, 1'b0, 1'b0},  // 19
        {1'b1, 8'h00, 3'd2, 1'b1, 1'b0},  // 20 R6 none ready -> idle
        {1'b1, 8'h00, 3'd2, 1'b1, 1'b0},  // 21 R9 stall while idle ignored
        {1'b0, 8'h04, 3'd2, 1'b0, 1'b0},  // 22 R8 same ctx, no flush
        {1'b1, 8'h00, 3'd2, 1'b1, 1'b0},  // 23 R6 idle again
        {1'b0, 8'h11, 3'd4, 1'b0, 1'b1},  // 24 R7 ctx0+4 wake, 4 wins
        {1'b0, 8'h00, 3'd4, 1'b0, 1'b1},  // 25
        {1'b0, 8'h00, 3'd4, 1'b0, 1'b1},  // 26
        {1'b0, 8'h00, 3'd4, 1'b0, 1'b0},  // 27
        {1'b0, 8'h01, 3'd4, 1'b0, 1'b0},  // 28 R9 wake ready ctx0
        {1'b1, 8'h10, 3'd0, 1'b0, 1'b1},  // 29 R5 self-wake ignored, 0
        {1'b0, 8'h00, 3'd0, 1'b0, 1'b1},  // 30
        {1'b0, 8'h00, 3'd0, 1'b0, 1'b1},  // 31
        {1'b0, 8'h00, 3'd0, 1'b0, 1'b0},  // 32
        {1'b1, 8'h00, 3'd0, 1'b1, 1'b0}   // 33 R6 lone ready stalls
    };

    task automatic check(input string req, input logic [2:0] eg,
                         input logic ei, input logic ef);
        n_checks++;
        if (grant_o !== eg || idle_o !== ei || flush_o !== ef) begin
            n_fails++;
            $display("FAIL %s: got grant=%0d idle=%0b flush=%0b, expected grant=%0d idle=%0b flush=%0b",
                     req, grant_o, idle_o, flush_o, eg, ei, ef);
        end
    endtask

    task automatic step(input logic s, input logic [7:0] w);
        stall_req_i = s;
        wake_i      = w;
        @(posedge clk);
        #1;
        stall_req_i = 1'b0;
        wake_i      = 8'h00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1 reset state", 3'd0, 1'b0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][13], VEC[k][12:5]);
            check($sformatf("vector %0d", k + 1),
                  VEC[k][4:2], VEC[k][1], VEC[k][0]);
        end

        // R3: leaving idle for a different context starts a flush.
        step(1'b0, 8'h02);
        check("R3 idle exit to other ctx", 3'd1, 1'b0, 1'b1);

        // R1: reset in mid-flush clears everything.
        rst_n = 1'b0;
        step(1'b0, 8'h00);
        rst_n = 1'b1;
        check("R1 reset during flush", 3'd0, 1'b0, 1'b0);

        // R1: other contexts are blocked after reset, so a stall idles.
        step(1'b1, 8'h00);
        check("R1 others blocked after reset", 3'd0, 1'b1, 1'b0);

        // R8: waking context 0 alone resumes it with no bubbles.
        step(1'b0, 8'h01);
        check("R8 regrant same ctx", 3'd0, 1'b0, 1'b0);

        finish_run();
    end

endmodule